// File: doc/BRIEF.md
# Masked Port Mismatch Interrupt Detector

This block watches a four-pin input group and one separate input pin. Each pin has a reference bit and an enable bit, and both are set through a small register interface. Every enabled pin in a group must equal its reference bit for that group to be "in match". The block raises an interrupt flag for a group only when the group goes from in match to out of match. Masked pins take no part in the decision. A change from one mismatch pattern to another mismatch pattern stays silent.

The four-pin group and the single pin each keep their own sticky interrupt flag. Software reads the flags and clears them by writing ones to a clear register. The pins pass through a two-flop synchronizer before they are compared. A combined interrupt request goes out whenever a set flag belongs to a group that has at least one pin enabled. The reference bit decides which edge fires for each pin: a reference of 0 makes a rising edge a mismatch, and a reference of 1 makes a falling edge a mismatch.

Top module: `mmi_detector`

## Requirements
- R1: After synchronous reset, all reference bits, enable bits and both flags are 0, irq is 0, and every register address reads 0.
- R2: Writes to address 0 set the group reference bits and writes to address 1 set the group enable bits (bit i belongs to pin i). Address 2 holds the single pin's reference in bit 0 and its enable in bit 1. Address 3 reads the group flag in bit 0 and the single-pin flag in bit 1. All of these read back as written.
- R3: A pin change that completes a match-to-mismatch transition shows up in the flag at the third rising clock edge after the change is applied. The flag is not set after two edges.
- R4: The group flag becomes 1 when the enabled group pins go from all equal to their reference bits to at least one differing. Otherwise the flag holds its value.
- R5: A masked pin has no effect. Changing a masked pin never sets the group flag.
- R6: While the group is already in mismatch, a further change of enabled pins that leaves the group in mismatch does not set the flag.
- R7: When no group pin is enabled, the group counts as in match and its flag is never set by pin activity.
- R8: The single pin follows the same match-to-mismatch rule with its own reference bit, enable bit and flag, independent of the group.
- R9: Writing address 3 with bit 0 set clears the group flag, and with bit 1 set clears the single-pin flag. A 0 in a bit leaves that flag unchanged.
- R10: If a flag's set event and its clear write fall on the same clock edge, the flag ends up 1.
- R11: irq is 1 exactly when the group flag is 1 and some group pin is enabled, or when the single-pin flag is 1 and the single pin is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_pins | input | GW | Four-pin group inputs, asynchronous |
| solo_pin | input | 1 | Separate single input pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW | Register read data, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A group flag can be set by a detected match-to-mismatch event on the same edge that software writes its clear bit. The bench provokes this by driving a mismatching pin pattern and timing the clear write to land exactly on the third edge after it, which is the edge where the synchronized event reaches the flag. The flag is then read back and must still be 1. A plain clear issued afterwards, with no event pending, must bring the flag to 0.

// File: rtl/mmi_pkg.sv
package mmi_pkg;
    localparam int GRP_W  = 4;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_GRP_REF  = 2'd0,
        SEL_GRP_EN   = 2'd1,
        SEL_SOLO_CFG = 2'd2,
        SEL_FLAGS    = 2'd3
    } reg_sel_e;

    // all enabled bits equal their reference; empty enable set counts as match
    function automatic logic pins_match(input logic [31:0] pins,
                                        input logic [31:0] ref_bits,
                                        input logic [31:0] en);
        return ((pins ^ ref_bits) & en) == 32'd0;
    endfunction
endpackage

// File: rtl/mmi_sync.sv
module mmi_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/mmi_fall_det.sv
module mmi_fall_det
    import mmi_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] ref_bits,
    input  logic [W-1:0] en,
    output logic         fire
);
    logic match_now;
    logic match_prev;

    always_comb begin
        match_now = pins_match(32'(pins), 32'(ref_bits), 32'(en));
        fire      = match_prev && !match_now;
    end

    always_ff @(posedge clk) begin
        if (rst) match_prev <= 1'b1;
        else     match_prev <= match_now;
    end
endmodule

// File: rtl/mmi_detector.sv
module mmi_detector
    import mmi_pkg::*;
#(
    parameter  int GW = GRP_W,
    localparam int DW = (GW > 2) ? GW : 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GW-1:0]     grp_pins,
    input  logic              solo_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq
);
    logic [GW-1:0] grp_ref_q;
    logic [GW-1:0] grp_en_q;
    logic          solo_ref_q;
    logic          solo_en_q;
    logic          grp_flag_q;
    logic          solo_flag_q;

    logic [GW:0]   sync_q;
    logic          grp_fire;
    logic          solo_fire;
    reg_sel_e      wsel;
    reg_sel_e      rsel;

    mmi_sync #(.W(GW + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({solo_pin, grp_pins}),
        .q   (sync_q)
    );

    mmi_fall_det #(.W(GW)) u_grp_det (
        .clk      (clk),
        .rst      (rst),
        .pins     (sync_q[GW-1:0]),
        .ref_bits (grp_ref_q),
        .en       (grp_en_q),
        .fire     (grp_fire)
    );

    mmi_fall_det #(.W(1)) u_solo_det (
        .clk      (clk),
        .rst      (rst),
        .pins     (sync_q[GW]),
        .ref_bits (solo_ref_q),
        .en       (solo_en_q),
        .fire     (solo_fire)
    );

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_ref_q   <= '0;
            grp_en_q    <= '0;
            solo_ref_q  <= 1'b0;
            solo_en_q   <= 1'b0;
            grp_flag_q  <= 1'b0;
            solo_flag_q <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wsel)
                    SEL_GRP_REF:  grp_ref_q <= wr_data[GW-1:0];
                    SEL_GRP_EN:   grp_en_q  <= wr_data[GW-1:0];
                    SEL_SOLO_CFG: begin
                        solo_ref_q <= wr_data[0];
                        solo_en_q  <= wr_data[1];
                    end
                    SEL_FLAGS: begin
                        if (wr_data[0]) grp_flag_q  <= 1'b0;
                        if (wr_data[1]) solo_flag_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            // a new event overrides a clear on the same edge
            if (grp_fire)  grp_flag_q  <= 1'b1;
            if (solo_fire) solo_flag_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_GRP_REF:  rd_data[GW-1:0] = grp_ref_q;
            SEL_GRP_EN:   rd_data[GW-1:0] = grp_en_q;
            SEL_SOLO_CFG: rd_data[1:0]    = {solo_en_q, solo_ref_q};
            SEL_FLAGS:    rd_data[1:0]    = {solo_flag_q, grp_flag_q};
            default:      rd_data         = '0;
        endcase
    end

    assign irq = (grp_flag_q && (|grp_en_q)) || (solo_flag_q && solo_en_q);
endmodule

// File: rtl/mmi_checker.sv
module mmi_checker
    import mmi_pkg::*;
#(
    parameter int GW = GRP_W,
    parameter int DW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              irq,
    input logic              flag_g,
    input logic              flag_s,
    input logic              fire_g,
    input logic              fire_s,
    input logic [GW-1:0]     en_g
);
    logic clr_g;
    assign clr_g = wr_en && (wr_addr == 2'd3) && wr_data[0];

    AST_GRP_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        fire_g |=> flag_g); // R4
    AST_GRP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!flag_g && !fire_g) |=> !flag_g); // R4
    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (en_g == '0) |-> !fire_g); // R7
    AST_SOLO_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        fire_s |=> flag_s); // R8
    AST_GRP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_g && !fire_g) |=> !flag_g); // R9
    AST_GRP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_g && !clr_g) |=> flag_g); // R9
    AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_g && fire_g) |=> flag_g); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!flag_g && !flag_s) |-> !irq); // R11
endmodule

bind mmi_detector mmi_checker #(.GW(GW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .flag_g  (grp_flag_q),
    .flag_s  (solo_flag_q),
    .fire_g  (grp_fire),
    .fire_s  (solo_fire),
    .en_g    (grp_en_q)
);

// File: tb/sim_mmi_detector.sv
`timescale 1ns/1ps
module sim_mmi_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] grp_pins = 4'b0000;
    logic       solo_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [3:0] wr_data = 4'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [3:0] rd_data;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mmi_detector u0 (
        .clk(clk), .rst(rst), .grp_pins(grp_pins), .solo_pin(solo_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // {grp_pins, solo_pin, expect group flag, expect solo flag}
    // config: group ref 1010, enable 1110; solo ref 0, enable 1
    localparam logic [6:0] VEC [10] = '{
        {4'b1010, 1'b0, 1'b0, 1'b0},
        {4'b1011, 1'b0, 1'b0, 1'b0},
        {4'b0011, 1'b0, 1'b1, 1'b0},
        {4'b0111, 1'b0, 1'b0, 1'b0},
        {4'b1010, 1'b1, 1'b0, 1'b1},
        {4'b1011, 1'b1, 1'b0, 1'b0},
        {4'b1000, 1'b0, 1'b1, 1'b0},
        {4'b1010, 1'b0, 1'b0, 1'b0},
        {4'b1110, 1'b0, 1'b1, 1'b0},
        {4'b1010, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1 reset read", r, 4'd0);
        end
        check("R1 reset irq", {3'b0, irq}, 4'd0);

        // R2 configuration and readback
        wr(2'd0, 4'b1010);
        wr(2'd1, 4'b1110);
        wr(2'd2, 4'b0010);
        rd(2'd0, r); check("R2 group ref", r, 4'b1010);
        rd(2'd1, r); check("R2 group en", r, 4'b1110);
        rd(2'd2, r); check("R2 solo cfg", r, 4'b0010);

        grp_pins = 4'b1010; solo_pin = 1'b0;
        settle();
        wr(2'd3, 4'b0011);

        // table walk: R4 R5 R6 R8
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            grp_pins = VEC[i][6:3];
            solo_pin = VEC[i][2];
            settle();
            rd(2'd3, r);
            check($sformatf("R4/R5/R6 group vec %0d", i), {3'b0, r[0]}, {3'b0, VEC[i][1]});
            check($sformatf("R8 solo vec %0d", i), {3'b0, r[1]}, {3'b0, VEC[i][0]});
            wr(2'd3, 4'b0011);
        end

        // R3 latency: group in match (1010) now
        @(negedge clk);
        grp_pins = 4'b0010;
        @(negedge clk); @(negedge clk);
        rd(2'd3, r); check("R3 not yet after two edges", {3'b0, r[0]}, 4'd0);
        @(negedge clk);
        rd(2'd3, r); check("R3 set at third edge", {3'b0, r[0]}, 4'd1);

        // R11 irq follows flag and enables
        check("R11 irq with flag", {3'b0, irq}, 4'd1);
        wr(2'd1, 4'b0000);
        rd(2'd3, r); check("R11 flag kept when disabled", {3'b0, r[0]}, 4'd1);
        check("R11 irq gated by empty enable", {3'b0, irq}, 4'd0);

        // R9 clear bit 1 leaves group flag alone, bit 0 clears it
        wr(2'd3, 4'b0010);
        rd(2'd3, r); check("R9 other clear bit ignored", {3'b0, r[0]}, 4'd1);
        wr(2'd3, 4'b0001);
        rd(2'd3, r); check("R9 group clear", {3'b0, r[0]}, 4'd0);

        // R7 no enabled pins: pin activity never fires
        grp_pins = 4'b0101; settle();
        grp_pins = 4'b1111; settle();
        grp_pins = 4'b0000; settle();
        rd(2'd3, r); check("R7 empty enable silent", {3'b0, r[0]}, 4'd0);
        check("R7 irq low", {3'b0, irq}, 4'd0);

        // R10 set and clear on the same edge
        grp_pins = 4'b1010;
        wr(2'd1, 4'b1110);
        settle();
        wr(2'd3, 4'b0011);
        rd(2'd3, r); check("R10 precondition clear", r, 4'd0);
        @(negedge clk);
        grp_pins = 4'b0010;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd3, r); check("R10 set wins over clear", {3'b0, r[0]}, 4'd1);
        wr(2'd3, 4'b0001);
        rd(2'd3, r); check("R9 clear alone after R10", {3'b0, r[0]}, 4'd0);

        // R8 solo masked: no event
        wr(2'd2, 4'b0000);
        solo_pin = 1'b0; settle();
        solo_pin = 1'b1; settle();
        rd(2'd3, r); check("R8 solo masked silent", {3'b0, r[1]}, 4'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule